// File: doc/BRIEF.md
# DMA Channel Request Priority Arbiter

This block sits in front of a DMA transfer engine and decides which of four channels is served next. Each channel raises a request line. Each channel also has a mask bit, and a masked channel is ignored. When no service is in progress, the arbiter picks one eligible channel and raises a registered one-hot grant together with a valid flag. The grant stays fixed until the engine pulses a completion input. After that pulse the grant drops for at least one cycle before the next decision.

A mode input, driven from a command register bit, selects how the winner is chosen. In fixed mode the lowest-numbered eligible channel always wins. In rotating mode the search starts at a rotation pointer and wraps upward. On every completion the pointer moves to the channel just above the one that was served, so that channel becomes the lowest rank and no active requester is starved. The mode is sampled only at the edge where a decision is made.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, valid is 0, the grant vector is all zeros and the rotation pointer is channel 0. The first rotating decision with requests on channels 0 and 3 therefore grants channel 0.
- R2: The grant vector has at most one bit set. Valid is 1 exactly when one grant bit is set. Bit i of the grant means channel i.
- R3: While valid is 0, an eligible request (request 1 and mask 0) present at a rising edge produces valid and a grant for an eligible channel after that same edge.
- R4: In fixed mode (mode input 0) the granted channel is the lowest-numbered eligible channel.
- R5: In rotating mode (mode input 1) the granted channel is the first eligible channel found when searching from the pointer upward, with channel 3 wrapping to channel 0.
- R6: A completion pulse sampled while valid is 1 clears valid and the grant at that edge. So valid is 0 for at least one cycle between two grants.
- R7: While valid is 1 and no completion arrives, the grant does not change, whatever happens on the requests, masks or mode.
- R8: A masked request is never granted, and masking leaves the rotation pointer unchanged.
- R9: A change of the mode input while a grant is held has no effect until the next decision. That decision uses the mode present at its edge.
- R10: A completion pulse while valid is 0 has no effect on the grant or the pointer. The pointer changes only on a completion of a held grant, and then becomes the served channel plus one, modulo 4, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Request line per channel |
| mask_i | input | 4 | Mask bit per channel, 1 blocks the request |
| rot_mode_i | input | 1 | Priority scheme: 0 fixed, 1 rotating |
| done_i | input | 1 | Completion pulse for the current grant |
| grant_o | output | 4 | One-hot grant, bit i means channel i |
| grant_vld_o | output | 1 | A grant is held |

## Verification
The rotation pointer cannot be read at the ports. It shows only through the winner of a later rotating decision. To see whether a masked request, an idle completion or a fixed-mode service moved the pointer, the stimulus first sets up that event. It then issues a rotating decision with several requests whose winner differs for each possible pointer value. A behavioural model tracks the pointer alongside and is compared every cycle through long random runs that mix modes, masks and completion timing.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   typedef enum logic {
      PRIO_FIXED  = 1'b0,
      PRIO_ROTATE = 1'b1
   } prio_mode_e;
endpackage

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
   parameter int N_CH = 4
) (
   input  logic [N_CH-1:0] elig_i,
   output logic [N_CH-1:0] win_o
);
   always_comb begin
      win_o = '0;
      for (int i = N_CH - 1; i >= 0; i--) begin
         if (elig_i[i]) begin
            win_o    = '0;
            win_o[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/arb_rot_pick.sv
module arb_rot_pick #(
   parameter int N_CH = 4,
   localparam int PW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic [N_CH-1:0] elig_i,
   input  logic [PW-1:0]   ptr_i,
   output logic [N_CH-1:0] win_o
);
   always_comb begin
      logic found;
      int   idx;
      win_o = '0;
      found = 1'b0;
      for (int i = 0; i < N_CH; i++) begin
         idx = (int'(ptr_i) + i) % N_CH;
         if (!found && elig_i[idx]) begin
            win_o[idx] = 1'b1;
            found      = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
   import dma_arb_pkg::*;
#(
   parameter int N_CH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] req_i,
   input  logic [N_CH-1:0] mask_i,
   input  logic            rot_mode_i,
   input  logic            done_i,
   output logic [N_CH-1:0] grant_o,
   output logic            grant_vld_o
);
   localparam int PW = (N_CH > 1) ? $clog2(N_CH) : 1;

   if (N_CH < 2) begin : g_bad_nch
      $error("dma_prio_arbiter: N_CH must be at least 2");
   end

   logic [N_CH-1:0] elig;
   logic [N_CH-1:0] fix_win, rot_win, pick;
   logic [N_CH-1:0] grant_q;
   logic            busy_q;
   logic [PW-1:0]   ptr_q, ptr_nxt;
   prio_mode_e      mode;

   for (genvar g = 0; g < N_CH; g++) begin : g_elig
      assign elig[g] = req_i[g] & ~mask_i[g];
   end

   assign mode = prio_mode_e'(rot_mode_i);

   arb_fixed_pick #(.N_CH(N_CH)) u_fix (
      .elig_i (elig),
      .win_o  (fix_win)
   );

   arb_rot_pick #(.N_CH(N_CH)) u_rot (
      .elig_i (elig),
      .ptr_i  (ptr_q),
      .win_o  (rot_win)
   );

   assign pick = (mode == PRIO_ROTATE) ? rot_win : fix_win;

   // next pointer: one above the channel being released, wrapping
   always_comb begin
      ptr_nxt = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (grant_q[i]) ptr_nxt = (i == N_CH - 1) ? '0 : PW'(i + 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         grant_q <= '0;
         ptr_q   <= '0;
      end else if (busy_q) begin
         if (done_i) begin
            busy_q  <= 1'b0;
            grant_q <= '0;
            ptr_q   <= ptr_nxt;
         end
      end else if (|elig) begin
         busy_q  <= 1'b1;
         grant_q <= pick;
      end
   end

   assign grant_o     = grant_q;
   assign grant_vld_o = busy_q;

   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));
   assert_vld_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld_o == (grant_o != '0));
   assert_decide_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_vld_o && |(req_i & ~mask_i)) |=> grant_vld_o);
   assert_grant_elig_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_vld_o) |-> |(grant_o & $past(req_i & ~mask_i)));
   assert_fixed_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(grant_vld_o) && !$past(rot_mode_i))
         |-> (((grant_o - 1'b1) & $past(req_i & ~mask_i)) == '0));
   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vld_o && done_i) |=> !grant_vld_o);
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vld_o && !done_i) |=> (grant_vld_o && $stable(grant_o)));
   assert_ptr_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_vld_o && done_i) |=> $stable(ptr_q));
   assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_vld_o && !(|(req_i & ~mask_i))) |=> !grant_vld_o);
endmodule

// File: tb/tb_dma_prio_arbiter.sv
`timescale 1ns/1ps
module tb_dma_prio_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] req = '0, mask = '0;
   logic       mode = 1'b0, done = 1'b0;
   logic [3:0] grant;
   logic       vld;

   int    n_checks = 0, n_errors = 0;
   bit    finished = 0;
   int    m_busy, m_ch, m_ptr;
   string m_tag;

   always #2.5 clk = ~clk;

   dma_prio_arbiter dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask),
      .rot_mode_i(mode), .done_i(done), .grant_o(grant), .grant_vld_o(vld)
   );

   // behavioural reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_ch = 0; m_ptr = 0; m_tag = "R1";
      end else if (m_busy != 0) begin
         if (done) begin
            m_busy = 0; m_ptr = (m_ch + 1) % 4; m_tag = "R6";
         end else m_tag = "R7";
      end else begin
         int e;
         e = req & ~mask;
         m_tag = "R3";
         if (e != 0) begin
            m_busy = 1;
            if (mode) begin
               m_tag = "R5";
               for (int k = 3; k >= 0; k--)
                  if (e[(m_ptr + k) % 4]) m_ch = (m_ptr + k) % 4;
            end else begin
               m_tag = "R4";
               for (int k = 3; k >= 0; k--) if (e[k]) m_ch = k;
            end
         end
      end
   end

   task automatic compare(input string tag);
      logic [3:0] eg;
      eg = (m_busy != 0) ? 4'(1 << m_ch) : 4'b0;
      n_checks++;
      if (grant !== eg || vld !== (m_busy != 0)) begin
         n_errors++;
         $display("FAIL %s: grant=%b vld=%b expected grant=%b vld=%0d",
                  tag, grant, vld, eg, m_busy);
      end
   endtask

   task automatic cyc(input logic [3:0] r, input logic [3:0] m,
                      input logic md, input logic dn, input string tag);
      req = r; mask = m; mode = md; done = dn;
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      cyc(4'b0000, 4'b0000, 1, 0, "R1");
      cyc(4'b1001, 4'b0000, 1, 0, "R1");   // pointer 0 -> channel 0
      cyc(4'b1001, 4'b0000, 1, 1, "R6");   // release, pointer 1
      cyc(4'b1111, 4'b0000, 0, 0, "R4");   // fixed -> channel 0
      cyc(4'b0000, 4'b1111, 1, 0, "R7");   // held across changes
      cyc(4'b1111, 4'b0000, 1, 0, "R9");   // mode change ignored while held
      cyc(4'b1111, 4'b0000, 1, 1, "R6");   // release, pointer 1
      cyc(4'b1111, 4'b0000, 1, 0, "R9");   // new mode used -> channel 1
      cyc(4'b1111, 4'b0000, 1, 1, "R6");   // pointer 2
      cyc(4'b1011, 4'b0000, 1, 0, "R5");   // from 2: channel 3
      cyc(4'b1011, 4'b0000, 1, 1, "R6");   // pointer wraps to 0
      cyc(4'b1111, 4'b1111, 1, 0, "R8");   // all masked: no grant
      cyc(4'b0011, 4'b0001, 1, 0, "R8");   // ch0 masked -> channel 1
      cyc(4'b0011, 4'b0001, 1, 1, "R6");   // pointer 2
      cyc(4'b0000, 4'b0000, 0, 1, "R10");  // idle done ignored
      cyc(4'b1111, 4'b0000, 1, 0, "R10");  // pointer still 2 -> channel 2
      cyc(4'b1111, 4'b0000, 1, 1, "R6");
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] r, m;
         logic md, dn;
         r  = 4'($urandom);
         m  = ($urandom % 4 == 0) ? 4'($urandom) : 4'b0;
         md = ($urandom % 8 == 0) ? ~mode : mode;
         dn = ($urandom % 3 == 0);
         req = r; mask = m; mode = md; done = dn;
         @(posedge clk);
         @(negedge clk);
         compare(m_tag);
      end
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule